// File: doc/BRIEF.md
# Row-Multiplexed Dot Matrix Scanner

This block refreshes a 5-column by 7-row LED character by lighting a single row at a time, fast enough that the eye sees a steady image. Each row holds a 5-bit pattern in an external row store. The scanner reads that store one row ahead of time and presents the pattern on five column enables while the matching row strobe is active.

A chain of counters advances on a multiplex clock-enable pulse: a divide-by-6 prescaler, then a position counter with 15 sub-slots per row, then a divide-by-7 row counter. A 3-bit brightness code sets how many of the 15 sub-slots light the row, which gives eight fixed duty steps from full on down to blank. A lamp-test bit lights every dot at the selected brightness. Reset clears the whole chain, so several scanners released from one reset stay in step.

Top module: `dot_row_scanner`

## Requirements
- R1: At most one bit of `row_strobe` is high in any cycle, and rows are visited in the order 0, 1, … 6, then 0 again.
- R2: The sub-slot index advances once every 6 tick pulses, and the row advances once every 90 tick pulses (6 × 15), counting from reset.
- R3: No counter in the chain moves in a cycle without `mux_tick`; the active row and the duty window stay put.
- R4: With sub-slot index s (0 to 14) within the row, the row strobe and columns are lit only when s < N, where N is 15, 8, 6, 4, 3, 2, 1, 0 for `bright_code` 0 to 7.
- R5: With `bright_code` = 3'b111 every row strobe and column enable is low, whatever the row data and lamp-test input.
- R6: While lit, `col_en[c]` equals bit (4 − c) of the active row's pattern, so pattern bit 4 drives column 0 and bit 0 drives column 4.
- R7: With `lamp_test` high, all five column enables are high whenever the row is lit, independent of the row data.
- R8: Reset returns the chain to row 0, sub-slot 0, prescaler 0; after release with no tick the read address is 0 and row 0 is the active row.
- R9: `ram_rd_addr` gives the row that is active in the following cycle, so a store with one cycle of read latency supplies the active row's pattern in the cycle that row is shown.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset, clears the counter chain |
| mux_tick | input | 1 | Clock-enable pulse that advances the counter chain |
| bright_code | input | 3 | Brightness code: 0 full, 7 blank |
| lamp_test | input | 1 | Lights all dots at the selected brightness |
| ram_rd_addr | output | 3 | Row index read from the row store, one cycle ahead |
| ram_rd_data | input | 5 | Row pattern returned by the store, one cycle after the address |
| row_strobe | output | 7 | One-hot row drive |
| col_en | output | 5 | Column enables for the active row |

## Verification
The bench sweeps all eight brightness codes with lamp test both off and on over a full 630-tick frame, checking every cycle against a tick-count model. This covers the duty edge at each code, where an off-by-one comparison would light one sub-slot too many or too few. A pass with gaps between ticks catches a chain that counts clock cycles in place of pulses. Row patterns are asymmetric, so a column order that is not reversed shows up at once. A stale read address would show the previous row's pattern on the first cycle of each row, and a reset in the middle of a frame must bring the display back to row 0.

// File: rtl/dms_pkg.sv
package dms_pkg;

    // Number of brightness positions per row slot; the duty table is tied to it.
    localparam int SUB_SLOTS = 15;
    localparam int SUB_W     = $clog2(SUB_SLOTS);

    typedef enum logic [2:0] {
        BR_FULL  = 3'd0,
        BR_L53   = 3'd1,
        BR_L40   = 3'd2,
        BR_L27   = 3'd3,
        BR_L20   = 3'd4,
        BR_L13   = 3'd5,
        BR_L07   = 3'd6,
        BR_BLANK = 3'd7
    } bright_e;

    // Number of lit sub-slots for each code.
    function automatic logic [SUB_W-1:0] lit_slots(input bright_e code);
        logic [SUB_W-1:0] n;
        case (code)
            BR_FULL:  n = SUB_W'(15);
            BR_L53:   n = SUB_W'(8);
            BR_L40:   n = SUB_W'(6);
            BR_L27:   n = SUB_W'(4);
            BR_L20:   n = SUB_W'(3);
            BR_L13:   n = SUB_W'(2);
            BR_L07:   n = SUB_W'(1);
            default:  n = SUB_W'(0);
        endcase
        return n;
    endfunction

endpackage

// File: rtl/dms_scan_counter.sv
module dms_scan_counter #(
    parameter int PRESCALE  = 6,
    parameter int SUB_SLOTS = 15,
    parameter int ROWS      = 7,
    localparam int PW = $clog2(PRESCALE),
    localparam int SW = $clog2(SUB_SLOTS),
    localparam int RW = $clog2(ROWS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    output logic [SW-1:0] sub_q,
    output logic [RW-1:0] row_q,
    output logic [RW-1:0] row_nxt
);

    typedef struct packed {
        logic [PW-1:0] pre;
        logic [SW-1:0] sub;
        logic [RW-1:0] row;
    } chain_t;

    chain_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (tick) begin
            if (st_q.pre == PW'(PRESCALE - 1)) begin
                st_d.pre = '0;
                if (st_q.sub == SW'(SUB_SLOTS - 1)) begin
                    st_d.sub = '0;
                    if (st_q.row == RW'(ROWS - 1)) begin
                        st_d.row = '0;
                    end else begin
                        st_d.row = st_q.row + RW'(1);
                    end
                end else begin
                    st_d.sub = st_q.sub + SW'(1);
                end
            end else begin
                st_d.pre = st_q.pre + PW'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sub_q   = st_q.sub;
    assign row_q   = st_q.row;
    assign row_nxt = st_d.row;

endmodule

// File: rtl/dms_duty_gate.sv
module dms_duty_gate
    import dms_pkg::*;
#(
    localparam int SW = SUB_W
) (
    input  logic [SW-1:0] sub_idx,
    input  logic [2:0]    code,
    output logic          lit
);

    logic [SW-1:0] limit;

    always_comb begin
        limit = lit_slots(bright_e'(code));
        lit   = (sub_idx < limit);
    end

endmodule

// File: rtl/dms_col_drive.sv
module dms_col_drive #(
    parameter int ROWS = 7,
    parameter int COLS = 5,
    localparam int RW = $clog2(ROWS)
) (
    input  logic [RW-1:0]   row_idx,
    input  logic [COLS-1:0] pattern,
    input  logic            lamp,
    input  logic            lit,
    output logic [ROWS-1:0] strobe,
    output logic [COLS-1:0] cols
);

    for (genvar r = 0; r < ROWS; r++) begin : g_row
        assign strobe[r] = lit && (row_idx == RW'(r));
    end

    // Highest pattern bit drives the leftmost column.
    for (genvar c = 0; c < COLS; c++) begin : g_col
        assign cols[c] = lit && (lamp || pattern[COLS-1-c]);
    end

endmodule

// File: rtl/dot_row_scanner.sv
module dot_row_scanner
    import dms_pkg::*;
#(
    parameter int PRESCALE = 6,
    parameter int ROWS     = 7,
    parameter int COLS     = 5,
    localparam int RW = $clog2(ROWS),
    localparam int SW = SUB_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            mux_tick,
    input  logic [2:0]      bright_code,
    input  logic            lamp_test,
    output logic [RW-1:0]   ram_rd_addr,
    input  logic [COLS-1:0] ram_rd_data,
    output logic [ROWS-1:0] row_strobe,
    output logic [COLS-1:0] col_en
);

    logic [SW-1:0] sub_q;
    logic [RW-1:0] row_q;
    logic [RW-1:0] row_nxt;
    logic          lit;

    dms_scan_counter #(
        .PRESCALE  (PRESCALE),
        .SUB_SLOTS (SUB_SLOTS),
        .ROWS      (ROWS)
    ) u_chain (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (mux_tick),
        .sub_q   (sub_q),
        .row_q   (row_q),
        .row_nxt (row_nxt)
    );

    dms_duty_gate u_duty (
        .sub_idx (sub_q),
        .code    (bright_code),
        .lit     (lit)
    );

    dms_col_drive #(
        .ROWS (ROWS),
        .COLS (COLS)
    ) u_drive (
        .row_idx (row_q),
        .pattern (ram_rd_data),
        .lamp    (lamp_test),
        .lit     (lit),
        .strobe  (row_strobe),
        .cols    (col_en)
    );

    // The store sees the row that will be active after this edge.
    assign ram_rd_addr = row_nxt;

endmodule

// File: rtl/dms_scan_checker.sv
module dms_scan_checker #(
    parameter int ROWS = 7,
    parameter int COLS = 5,
    localparam int RW = $clog2(ROWS)
) (
    input logic            clk,
    input logic            rst_n,
    input logic            mux_tick,
    input logic [2:0]      bright_code,
    input logic [RW-1:0]   ram_rd_addr,
    input logic [RW-1:0]   row_q,
    input logic [ROWS-1:0] row_strobe,
    input logic [COLS-1:0] col_en
);

    // R1
    row_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(row_strobe));

    // R1
    row_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ram_rd_addr < RW'(ROWS));

    // R3
    hold_still_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(mux_tick) |-> $stable(row_q));

    // R4
    full_duty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bright_code == 3'd0) |-> ($countones(row_strobe) == 1));

    // R5
    blank_dark_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bright_code == 3'd7) |-> (row_strobe == '0 && col_en == '0));

    // R6
    col_needs_row_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (col_en != '0) |-> (row_strobe != '0));

    // R9
    addr_ahead_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (row_q == $past(ram_rd_addr)));

endmodule

bind dot_row_scanner dms_scan_checker #(
    .ROWS (ROWS),
    .COLS (COLS)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .mux_tick    (mux_tick),
    .bright_code (bright_code),
    .ram_rd_addr (ram_rd_addr),
    .row_q       (row_q),
    .row_strobe  (row_strobe),
    .col_en      (col_en)
);

// File: tb/dot_row_scanner_tb.sv
`timescale 1ns/1ps
module dot_row_scanner_tb;

    localparam int PRE  = 6;
    localparam int SUBS = 15;
    localparam int ROWS = 7;
    localparam int COLS = 5;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mux_tick = 1'b0;
    logic [2:0] bright_code = 3'd0;
    logic       lamp_test = 1'b0;
    logic [2:0] ram_rd_addr;
    logic [4:0] ram_rd_data = '0;
    logic [6:0] row_strobe;
    logic [4:0] col_en;

    logic [4:0] mem [ROWS];
    int total = 0;
    int bad = 0;
    int tcount = 0;

    always #2.5 clk = ~clk;

    // Row store with one cycle of read latency.
    always @(posedge clk) ram_rd_data <= mem[ram_rd_addr];

    dot_row_scanner u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .mux_tick    (mux_tick),
        .bright_code (bright_code),
        .lamp_test   (lamp_test),
        .ram_rd_addr (ram_rd_addr),
        .ram_rd_data (ram_rd_data),
        .row_strobe  (row_strobe),
        .col_en      (col_en)
    );

    task automatic chk(input string tag, input int got, input int exp);
        total++;
        if (got != exp) begin
            bad++;
            $display("FAIL %s t=%0d got=%0h exp=%0h", tag, tcount, got, exp);
        end
    endtask

    function automatic int duty_n(input int code);
        case (code)
            0: return 15;
            1: return 8;
            2: return 6;
            3: return 4;
            4: return 3;
            5: return 2;
            6: return 1;
            default: return 0;
        endcase
    endfunction

    function automatic int row_of(input int t);
        return (t / (PRE * SUBS)) % ROWS;
    endfunction

    task automatic check_now(input string tag);
        int row, sub, lit, ecol, estr;
        row = row_of(tcount);
        sub = (tcount / PRE) % SUBS;
        lit = (sub < duty_n(int'(bright_code))) ? 1 : 0;
        estr = lit ? (1 << row) : 0;
        ecol = 0;
        for (int c = 0; c < COLS; c++) begin
            if (lit != 0 && (lamp_test || mem[row][COLS-1-c])) ecol |= (1 << c);
        end
        chk({tag, " R1/R2/R4 strobe"}, int'(row_strobe), estr);
        if (bright_code == 3'd7) chk({tag, " R5 dark"}, int'(col_en), 0);
        else if (lamp_test) chk({tag, " R7 lamp cols"}, int'(col_en), ecol);
        else chk({tag, " R6 cols"}, int'(col_en), ecol);
        chk({tag, " R9 addr"}, int'(ram_rd_addr), row_of(tcount + int'(mux_tick)));
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        mux_tick = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        tcount = 0;
        #1;
        chk("R8 reset addr", int'(ram_rd_addr), 0);
        chk("R8 reset strobe", int'(row_strobe), (bright_code != 3'd7) ? 1 : 0);
    endtask

    task automatic run(input int n, input int gap, input int code, input bit lamp,
                       input string tag);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            bright_code = 3'(code);
            lamp_test = lamp;
            mux_tick = ((i % gap) == 0);
            #1;
            check_now(tag);
            @(posedge clk);
            if (mux_tick) tcount++;
        end
    endtask

    initial begin
        #750000;
        total++;
        bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        // Asymmetric patterns so column order errors show.
        mem[0] = 5'h11; mem[1] = 5'h12; mem[2] = 5'h14; mem[3] = 5'h18;
        mem[4] = 5'h03; mem[5] = 5'h16; mem[6] = 5'h09;
        do_reset();
        for (int code = 0; code < 8; code++) begin
            for (int lamp = 0; lamp < 2; lamp++) begin
                run(PRE * SUBS * ROWS, 1, code, 1'(lamp), "sweep");
            end
        end
        // R3: ticks only every third cycle.
        run(400, 3, 2, 1'b0, "R3 gapped");
        run(200, 4, 0, 1'b0, "R3 gapped full");
        // R8: reset in mid frame, new patterns loaded while held.
        @(negedge clk);
        rst_n = 1'b0;
        for (int r = 0; r < ROWS; r++) mem[r] = 5'((r * 7 + 3) & 31);
        bright_code = 3'd0;
        do_reset();
        run(PRE * SUBS * ROWS + 20, 1, 0, 1'b0, "R8 after reset");
        run(300, 1, 7, 1'b1, "R5 blank lamp");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule